// File: doc/BRIEF.md
# Zero-Current Guard for a Half-Bridge Resonant Converter

This block supervises the gate intervals of a half-bridge resonant power stage. It keeps the stage out of the capacitive region. Two comparators report whether the sensed tank current is above a threshold: one serves the high-side interval and one serves the low-side interval. The block reads only the comparator that belongs to the gate currently on. Once that comparator has shown current above threshold after the blanking window, a later drop below threshold ends the gate pulse early. The pulse does not wait for the capacitor-voltage crossing.

Every such event raises a ramp-down request for the soft-start generator, which pushes the switching frequency upward. The request stays up until enough clean switching cycles have passed. If the request lasts longer than a programmable number of clock cycles, the block latches a fault and drops the gate enable. The fault stays latched until a synchronous clear.

The blanking window that starts at every gate rising edge is also driven out, so the capacitor-voltage comparators share one blanking setting. The comparator inputs are asynchronous and pass through a two-stage synchronizer.

Top module: `zcs_guard`

## Requirements
- R1: After a synchronous reset with both gates low, `zcsKill`, `rampDown`, `fault` and `vcrBlank` are low and `gateEnable` is high.
- R2: While `hiGate` alone is high, only `zcsHiRaw` is used; while `loGate` alone is high, only `zcsLoRaw` is used. The unused comparator has no effect. When both gates are high, no detection occurs.
- R3: Comparator level 1 means current above threshold. Take a gate raised just before rising edge 1, with comparator changes applied between edges. A fall applied after edge f trips only if the comparator went high at least one edge earlier. The trip then produces a one-cycle `zcsKill` after edge f+3. There is at most one trip per gate interval.
- R4: `vcrBlank` is high from the first cycle a gate is high through the next `blankCycles` cycles. Comparator readings in that window neither arm nor trip, so a fall applied after edge f trips only if f >= `blankCycles`.
- R5: `rampDown` rises in the same cycle as `zcsKill` and stays high while events recur.
- R6: If `rampDown` stays high, `fault` rises `persistLimit`+1 clock cycles after the `zcsKill` cycle.
- R7: While `fault` is high, `gateEnable` is low and no `zcsKill` is produced. The fault holds until `faultClear` is sampled high, which clears `fault` and `rampDown`.
- R8: A gate interval ends when its gate goes low. After `cleanLimit` consecutive intervals end without a trip, `rampDown` falls and the persistence timer restarts.
- R9: `pulseEnd` is high exactly in the cycles where `vcrEnd` or `zcsKill` is high. When both are high in the same cycle, the result is a single one-cycle `pulseEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hiGate | input | 1 | High-side gate state |
| loGate | input | 1 | Low-side gate state |
| zcsHiRaw | input | 1 | Asynchronous comparator for the high-side interval, 1 = current above threshold |
| zcsLoRaw | input | 1 | Asynchronous comparator for the low-side interval, 1 = current above threshold |
| vcrEnd | input | 1 | Normal end-of-pulse request from the capacitor-voltage comparators |
| blankCycles | input | BLANK_W | Blanking length after each gate rising edge |
| persistLimit | input | PERSIST_W | Persistence time-out in clock cycles |
| cleanLimit | input | CLEAN_W | Clean intervals needed to drop the ramp-down request |
| faultClear | input | 1 | Synchronous fault clear |
| pulseEnd | output | 1 | Combined end-of-pulse request |
| zcsKill | output | 1 | One-cycle early-termination strobe |
| rampDown | output | 1 | Soft-start ramp-down request |
| fault | output | 1 | Latched persistent-event fault |
| gateEnable | output | 1 | Gate enable, low in fault |
| vcrBlank | output | 1 | Shared blanking window for both comparator sets |

## Verification
The early-termination strobe and the normal capacitor-voltage end request can land in the same cycle, and both feed the one end-of-pulse output. The bench schedules `vcrEnd` so it is high in exactly the cycle where the strobe is predicted from the comparator fall. It then expects one high cycle on `pulseEnd` with `zcsKill` and `rampDown` high, and low outputs in the cycle after. A second `vcrEnd` pulse, with no event, must still produce `pulseEnd` while `zcsKill` stays low.

// File: rtl/zcs_guard_pkg.sv
package zcs_guard_pkg;

  typedef enum logic [1:0] {
    QUAL_IDLE,
    QUAL_WAIT,
    QUAL_ARMED,
    QUAL_SPENT
  } qualState_e;

  // status the datapath hands to the control
  typedef struct packed {
    logic gateRise;
    logic gateFall;
    logic phaseValid;
    logic blanked;
    logic cmpLevel;
    logic persistDone;
    logic cleanDone;
  } dpStatus_t;

  // strobes the control hands to the datapath
  typedef struct packed {
    logic persistRun;
    logic persistClr;
    logic cleanInc;
    logic cleanClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/zcs_guard_dp.sv
module zcs_guard_dp
  import zcs_guard_pkg::*;
#(
  parameter int BLANK_W     = 8,
  parameter int PERSIST_W   = 16,
  parameter int CLEAN_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hiGate,
  input  logic                 loGate,
  input  logic                 zcsHiRaw,
  input  logic                 zcsLoRaw,
  input  logic [BLANK_W-1:0]   blankCycles,
  input  logic [PERSIST_W-1:0] persistLimit,
  input  logic [CLEAN_W-1:0]   cleanLimit,
  input  ctrlStrobe_t          strobe,
  output dpStatus_t            status
);

  localparam int NUM_CH    = 2;
  localparam int CLEAN_EXT = CLEAN_W + 1;

  logic [NUM_CH-1:0] rawCmp;
  logic [NUM_CH-1:0] syncCmp;

  assign rawCmp = {zcsLoRaw, zcsHiRaw};

  // one synchronizer chain per comparator channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], rawCmp[ch]};
    end
    assign syncCmp[ch] = chain[SYNC_STAGES-1];
  end

  logic hiPrev, loPrev, validPrev;
  logic phaseValid, gateRise, gateFall;

  assign phaseValid = hiGate ^ loGate;
  assign gateRise   = (hiGate & ~hiPrev) | (loGate & ~loPrev);
  assign gateFall   = validPrev & ~phaseValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiPrev    <= 1'b0;
      loPrev    <= 1'b0;
      validPrev <= 1'b0;
    end else begin
      hiPrev    <= hiGate;
      loPrev    <= loGate;
      validPrev <= phaseValid;
    end
  end

  // blanking window shared with the capacitor-voltage comparators
  logic [BLANK_W-1:0] blankCnt;

  always_ff @(posedge clk) begin
    if (rst)                  blankCnt <= '0;
    else if (gateRise)        blankCnt <= blankCycles;
    else if (blankCnt != '0)  blankCnt <= blankCnt - BLANK_W'(1);
  end

  // persistence timer in clock cycles
  logic [PERSIST_W-1:0] persistCnt;
  logic                 persistDone;

  assign persistDone = (persistCnt >= persistLimit);

  always_ff @(posedge clk) begin
    if (rst)                                 persistCnt <= '0;
    else if (strobe.persistClr)              persistCnt <= '0;
    else if (strobe.persistRun && !persistDone)
      persistCnt <= persistCnt + PERSIST_W'(1);
  end

  // consecutive clean gate intervals
  logic [CLEAN_W-1:0] cleanCnt;
  logic               cleanDone;

  assign cleanDone = (({1'b0, cleanCnt} + CLEAN_EXT'(1)) >= {1'b0, cleanLimit});

  always_ff @(posedge clk) begin
    if (rst)                  cleanCnt <= '0;
    else if (strobe.cleanClr) cleanCnt <= '0;
    else if (strobe.cleanInc) cleanCnt <= cleanCnt + CLEAN_W'(1);
  end

  always_comb begin
    status.gateRise    = gateRise;
    status.gateFall    = gateFall;
    status.phaseValid  = phaseValid;
    status.blanked     = gateRise | (blankCnt != '0);
    status.cmpLevel    = hiGate ? syncCmp[0] : syncCmp[1];
    status.persistDone = persistDone;
    status.cleanDone   = cleanDone;
  end

endmodule

// File: rtl/zcs_guard_ctrl.sv
module zcs_guard_ctrl
  import zcs_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        faultClear,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        zcsKill,
  output logic        rampDown,
  output logic        fault
);

  qualState_e qual, nextQual;
  logic       trip;
  logic       killQ, eventQ, faultQ;
  logic       cleanFall, clearEvent, faultSet;

  // per-interval qualification: wait for current above threshold, then a fall
  always_comb begin
    nextQual = qual;
    trip     = 1'b0;
    if (!status.phaseValid) begin
      nextQual = QUAL_IDLE;
    end else if (status.gateRise) begin
      nextQual = QUAL_WAIT;
    end else begin
      case (qual)
        QUAL_WAIT: begin
          if (!status.blanked && status.cmpLevel) nextQual = QUAL_ARMED;
        end
        QUAL_ARMED: begin
          if (!status.cmpLevel) begin
            trip     = !faultQ;
            nextQual = QUAL_SPENT;
          end
        end
        QUAL_SPENT: nextQual = QUAL_SPENT;
        default:    nextQual = QUAL_IDLE;
      endcase
    end
  end

  assign cleanFall  = status.gateFall && (qual != QUAL_SPENT) && eventQ && !faultQ;
  assign clearEvent = cleanFall && status.cleanDone;
  assign faultSet   = eventQ && !faultQ && status.persistDone;

  always_comb begin
    strobe.persistRun = eventQ && !faultQ;
    strobe.persistClr = clearEvent | faultClear;
    strobe.cleanInc   = cleanFall && !status.cleanDone;
    strobe.cleanClr   = trip | clearEvent | faultClear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual   <= QUAL_IDLE;
      killQ  <= 1'b0;
      eventQ <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      qual  <= nextQual;
      killQ <= trip;
      if (faultClear)      eventQ <= 1'b0;
      else if (trip)       eventQ <= 1'b1;
      else if (clearEvent) eventQ <= 1'b0;
      if (faultClear)      faultQ <= 1'b0;
      else if (faultSet)   faultQ <= 1'b1;
    end
  end

  assign zcsKill  = killQ;
  assign rampDown = eventQ;
  assign fault    = faultQ;

endmodule

// File: rtl/zcs_guard.sv
module zcs_guard
  import zcs_guard_pkg::*;
#(
  parameter int BLANK_W     = 8,
  parameter int PERSIST_W   = 16,
  parameter int CLEAN_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hiGate,
  input  logic                 loGate,
  input  logic                 zcsHiRaw,
  input  logic                 zcsLoRaw,
  input  logic                 vcrEnd,
  input  logic [BLANK_W-1:0]   blankCycles,
  input  logic [PERSIST_W-1:0] persistLimit,
  input  logic [CLEAN_W-1:0]   cleanLimit,
  input  logic                 faultClear,
  output logic                 pulseEnd,
  output logic                 zcsKill,
  output logic                 rampDown,
  output logic                 fault,
  output logic                 gateEnable,
  output logic                 vcrBlank
);

  dpStatus_t   status;
  ctrlStrobe_t strobe;

  zcs_guard_dp #(
    .BLANK_W    (BLANK_W),
    .PERSIST_W  (PERSIST_W),
    .CLEAN_W    (CLEAN_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .hiGate      (hiGate),
    .loGate      (loGate),
    .zcsHiRaw    (zcsHiRaw),
    .zcsLoRaw    (zcsLoRaw),
    .blankCycles (blankCycles),
    .persistLimit(persistLimit),
    .cleanLimit  (cleanLimit),
    .strobe      (strobe),
    .status      (status)
  );

  zcs_guard_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .faultClear(faultClear),
    .status    (status),
    .strobe    (strobe),
    .zcsKill   (zcsKill),
    .rampDown  (rampDown),
    .fault     (fault)
  );

  assign pulseEnd   = vcrEnd | zcsKill;
  assign gateEnable = ~fault;
  assign vcrBlank   = status.blanked;

endmodule

// File: rtl/zcs_guard_chk.sv
module zcs_guard_chk (
  input logic clk,
  input logic rst,
  input logic hiGate,
  input logic loGate,
  input logic faultClear,
  input logic zcsKill,
  input logic rampDown,
  input logic fault,
  input logic vcrBlank
);

  p_kill_single_r3: assert property (@(posedge clk) disable iff (rst)
    zcsKill |=> !zcsKill);

  p_kill_one_gate_r2: assert property (@(posedge clk) disable iff (rst)
    zcsKill |-> $past(hiGate ^ loGate));

  p_kill_unblanked_r4: assert property (@(posedge clk) disable iff (rst)
    zcsKill |-> !$past(vcrBlank));

  p_ramp_with_kill_r5: assert property (@(posedge clk) disable iff (rst)
    zcsKill |-> rampDown);

  p_fault_after_ramp_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(rampDown));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fault && !faultClear) |=> fault);

  p_no_kill_in_fault_r7: assert property (@(posedge clk) disable iff (rst)
    fault |=> !zcsKill);

endmodule

bind zcs_guard zcs_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hiGate    (hiGate),
  .loGate    (loGate),
  .faultClear(faultClear),
  .zcsKill   (zcsKill),
  .rampDown  (rampDown),
  .fault     (fault),
  .vcrBlank  (vcrBlank)
);

// File: tb/zcs_guard_test.sv
module zcs_guard_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hiGate = 1'b0, loGate = 1'b0;
  logic        zcsHiRaw = 1'b0, zcsLoRaw = 1'b0;
  logic        vcrEnd = 1'b0, faultClear = 1'b0;
  logic [7:0]  blankCycles = 8'd0;
  logic [15:0] persistLimit = 16'd1000;
  logic [3:0]  cleanLimit = 4'd1;
  logic        pulseEnd, zcsKill, rampDown, fault, gateEnable, vcrBlank;

  int errCount = 0;
  int chkCount = 0;

  // interval observations
  int killAt, killCount, faultAt, blankHigh, endBad, pulseHigh;

  always #10 clk = ~clk;

  zcs_guard uut (
    .clk(clk), .rst(rst), .hiGate(hiGate), .loGate(loGate),
    .zcsHiRaw(zcsHiRaw), .zcsLoRaw(zcsLoRaw), .vcrEnd(vcrEnd),
    .blankCycles(blankCycles), .persistLimit(persistLimit),
    .cleanLimit(cleanLimit), .faultClear(faultClear),
    .pulseEnd(pulseEnd), .zcsKill(zcsKill), .rampDown(rampDown),
    .fault(fault), .gateEnable(gateEnable), .vcrBlank(vcrBlank)
  );

  // {side(0 hi,1 lo), blankCycles, rise index h, fall index f, expected kill sample}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{0, 2, 0, 6,  9},
    '{0, 4, 0, 4,  7},
    '{0, 4, 0, 3,  0},
    '{0, 1, 5, 6,  9},
    '{0, 1, 5, 5,  0},
    '{0, 0, 0, 1,  4},
    '{1, 2, 1, 8, 11},
    '{0, 1, 0, 20, 0}
  };

  task automatic check(input string tag, input int act, input int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic driveGate(input int side, input bit act, input bit other);
    hiGate   = (side == 0 || side == 2);
    loGate   = (side == 1 || side == 2);
    zcsHiRaw = (side == 1) ? other : act;
    zcsLoRaw = (side == 1) ? act : other;
  endtask

  // one gate interval of len samples; active comparator high on drives [h,f),
  // the other comparator high on drives [1,4); vcrEnd high for sample vcrAt
  task automatic runGate(input int side, input int h, input int f, input int len, input int vcrAt);
    killAt = 0; killCount = 0; faultAt = 0; blankHigh = 0; endBad = 0; pulseHigh = 0;
    driveGate(side, (0 >= h && 0 < f), 1'b0);
    vcrEnd = (vcrAt == 1);
    for (int k = 1; k <= len; k++) begin
      step();
      if (zcsKill) begin killCount++; killAt = k; end
      if (fault && faultAt == 0) faultAt = k;
      if (vcrBlank) blankHigh++;
      if (pulseEnd) pulseHigh++;
      if (pulseEnd != (zcsKill | vcrEnd)) endBad++;
      driveGate(side, (k >= h && k < f), (k >= 1 && k < 4));
      vcrEnd = (k + 1 == vcrAt);
    end
  endtask

  task automatic gatesOff(input int n);
    hiGate = 0; loGate = 0; zcsHiRaw = 0; zcsLoRaw = 0; vcrEnd = 0;
    repeat (n) step();
  endtask

  task automatic clearFault();
    faultClear = 1'b1;
    step();
    faultClear = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCount++;
    chkCount++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    check("R1 zcsKill after reset", zcsKill, 0);
    check("R1 rampDown after reset", rampDown, 0);
    check("R1 fault after reset", fault, 0);
    check("R1 gateEnable after reset", gateEnable, 1);
    check("R1 vcrBlank after reset", vcrBlank, 0);

    // vector table: R2, R3, R4, R5, R9
    for (int i = 0; i < NVEC; i++) begin
      blankCycles  = 8'(VEC[i][1]);
      persistLimit = 16'd1000;
      cleanLimit   = 4'd1;
      clearFault();
      runGate(VEC[i][0], VEC[i][2], VEC[i][3], 16, 0);
      check((VEC[i][0] == 1 || i == 7) ? "R2 kill sample, other comparator toggling" : "R3 kill sample",
            killAt, VEC[i][4]);
      check("R3 kill strobe count", killCount, (VEC[i][4] != 0) ? 1 : 0);
      check("R4 blanking window length", blankHigh, VEC[i][1]);
      check("R9 pulseEnd follows strobe", endBad, 0);
      check("R5 rampDown after interval", rampDown, (VEC[i][4] != 0) ? 1 : 0);
      gatesOff(3);
    end

    // R2: both gates high disables detection
    blankCycles = 8'd0;
    clearFault();
    runGate(2, 0, 1, 10, 0);
    check("R2 no kill with both gates high", killCount, 0);
    gatesOff(3);

    // R6 and R7: persistence time-out and latched fault
    blankCycles  = 8'd0;
    persistLimit = 16'd5;
    clearFault();
    runGate(0, 0, 1, 14, 0);
    check("R6 kill sample before time-out", killAt, 4);
    check("R6 fault sample", faultAt, 10);
    check("R7 gateEnable low in fault", gateEnable, 0);
    gatesOff(3);
    runGate(0, 0, 1, 10, 0);
    check("R7 no kill while in fault", killCount, 0);
    check("R7 fault held", fault, 1);
    gatesOff(3);
    clearFault();
    check("R7 fault cleared", fault, 0);
    check("R7 gateEnable restored", gateEnable, 1);
    check("R7 rampDown cleared", rampDown, 0);

    // R8: clean intervals drop the ramp-down request
    persistLimit = 16'd1000;
    cleanLimit   = 4'd2;
    clearFault();
    runGate(0, 0, 1, 8, 0);
    gatesOff(3);
    check("R8 rampDown after event", rampDown, 1);
    runGate(0, 20, 20, 8, 0);
    gatesOff(3);
    check("R8 rampDown after one clean interval", rampDown, 1);
    runGate(0, 20, 20, 8, 0);
    gatesOff(3);
    check("R8 rampDown after two clean intervals", rampDown, 0);

    // R9: vcrEnd in the same cycle as the strobe, then vcrEnd alone
    cleanLimit = 4'd1;
    clearFault();
    runGate(0, 0, 3, 8, 6);
    check("R9 kill in coincidence cycle", killAt, 6);
    check("R9 single pulseEnd for coincidence", pulseHigh, 1);
    check("R9 pulseEnd consistency", endBad, 0);
    check("R5 rampDown with coincident end", rampDown, 1);
    gatesOff(3);
    runGate(0, 20, 20, 6, 3);
    check("R9 pulseEnd from vcrEnd alone", pulseHigh, 1);
    check("R9 no kill on vcrEnd alone", killCount, 0);
    gatesOff(3);

    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule